// File: doc/BRIEF.md
# Per-Locality Interrupt Controller

This block holds one interrupt-enable register and one interrupt-status register for each locality, and drives a single interrupt line that all localities share. Elsewhere in the chip, event logic raises single-cycle event pulses: data available, status valid, locality changed and command ready. Each pulse carries the number of the locality it belongs to. The block latches an event into that locality's status only when the locality has both its global enable and that source's enable set. When an event latches, the line is raised.

Software writes the enable and status registers through a simple write port. A write carries a locality number, a register select, byte enables and data. Only the currently active locality, given on `active_loc_i`, may change its registers. Status bits are cleared by writing ones. The line drops only when such a clear empties the status of the locality that wrote. A combinational read port returns the enable or status register of any locality. It also returns a fixed vector register that holds the configured interrupt number.

Top module: `loc_irq_ctrl`

## Requirements
- R1: After reset every locality's enable register reads 0x0000_0008, meaning low-level polarity with every source off. Every status register reads 0 and `irq_o` is low.
- R2: An event pulse for locality L sets status bits only when bit 31 (global enable) of L's enable register is set and the matching source enable is also set. The source mapping is: `evt_i[0]` is data available and maps to bit 0, `evt_i[1]` is status valid and maps to bit 1, `evt_i[2]` is locality changed and maps to bit 2, and `evt_i[3]` is command ready and maps to bit 7. `irq_o` goes high in the cycle after an event latches.
- R3: An event whose global enable or source enable is clear leaves the status unchanged and does not raise `irq_o`.
- R4: An event tagged with a locality of NUM_LOC or above, including 0xFF, changes no status register and does not raise `irq_o`.
- R5: A write with `wr_loc_i` different from `active_loc_i` has no effect. A write while `active_loc_i` is NUM_LOC or above also has no effect.
- R6: Only enable bits 31, 7, 4, 3, 2, 1 and 0 are writable (mask 0x8000_009F). All other enable bits always read 0.
- R7: An enable write updates only the bytes whose `wr_be_i` bit is set. Byte b covers bits 8b+7 to 8b.
- R8: A status write (select 1) with `wr_be_i[0]` set clears every status bit where `wr_data_i` holds a one. `irq_o` falls in the next cycle if that write cleared at least one set bit and left the writer's status at zero. Status bits still set in other localities do not hold the line up.
- R9: Read select 2 returns the IRQ_NUM parameter, limited to the range 0 to 15. Writes with select 2 or 3 change nothing.
- R10: When an event latches in the same cycle as a clearing write, the latched bit stays set and `irq_o` is high afterwards.
- R11: Read select 0 returns the enable register and select 1 the status register of locality `rd_loc_i`. The read is combinational and has no effect on state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_valid_i | input | 1 | Event pulse strobe |
| evt_loc_i | input | 8 | Locality of the event |
| evt_i | input | 4 | Event sources: 0 data available, 1 status valid, 2 locality changed, 3 command ready |
| active_loc_i | input | 8 | Currently active locality, 0xFF when none |
| wr_en_i | input | 1 | Register write strobe |
| wr_loc_i | input | 8 | Locality issuing the write |
| wr_sel_i | input | 2 | Write target: 0 enable, 1 status, 2 vector |
| wr_be_i | input | 4 | Byte enables |
| wr_data_i | input | 32 | Write data |
| rd_loc_i | input | 8 | Locality to read |
| rd_sel_i | input | 2 | Read target: 0 enable, 1 status, 2 vector |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 1 | Shared interrupt line, active high |

## Verification
The bench builds the block with NUM_LOC of 5 and IRQ_NUM of 11. With these values the vector readback and every locality up to the first invalid number, 5, can be reached. The random phase draws event and write localities from 0 to 7 and 0xFF. It also moves the active locality around, so writes from non-active localities and events for localities that do not exist occur often. Directed cases cover partial clears that keep the line up, a clear that drops the line while another locality still holds status, byte-lane enable writes, and an event that coincides with a clearing write.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic [1:0]  SEL_ENABLE = 2'd0;
  localparam logic [1:0]  SEL_STATUS = 2'd1;
  localparam logic [1:0]  SEL_VECTOR = 2'd2;
  localparam logic [31:0] IEN_MASK   = 32'h8000_009F;
  localparam logic [31:0] SRC_MASK   = 32'h0000_0087;
  localparam logic [31:0] IEN_RESET  = 32'h0000_0008;
  localparam int          GLOBAL_BIT = 31;

  function automatic logic [31:0] map_evt(logic [3:0] e);
    return {24'b0, e[3], 4'b0, e[2:0]};
  endfunction
endpackage

// File: rtl/irq_evt_decode.sv
module irq_evt_decode #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 8
) (
  input  logic             evt_valid_i,
  input  logic [LOC_W-1:0] evt_loc_i,
  input  logic [3:0]       evt_i,
  output logic [NUM_LOC-1:0] hit_o,
  output logic [31:0]      bits_o
);
  for (genvar i = 0; i < NUM_LOC; i++) begin : g_hit
    assign hit_o[i] = evt_valid_i && (evt_loc_i == LOC_W'(i));
  end
  assign bits_o = irq_pkg::map_evt(evt_i);
endmodule

// File: rtl/irq_loc_bank.sv
module irq_loc_bank (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        evt_hit_i,
  input  logic [31:0] evt_bits_i,
  input  logic        wr_ien_i,
  input  logic        wr_ist_i,
  input  logic [3:0]  wr_be_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] ien_o,
  output logic [31:0] ist_o,
  output logic        latch_o,
  output logic        drop_o
);
  import irq_pkg::*;

  logic [31:0] ien_q, ien_d, ist_q, ist_d;
  logic [31:0] set_bits, clr_bits;

  assign set_bits = (evt_hit_i && ien_q[GLOBAL_BIT]) ? (evt_bits_i & ien_q & SRC_MASK) : '0;
  assign clr_bits = (wr_ist_i && wr_be_i[0]) ? ({24'b0, wr_data_i[7:0]} & SRC_MASK) : '0;
  assign ist_d    = (ist_q & ~clr_bits) | set_bits;

  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign ien_d[8*b +: 8] = (wr_ien_i && wr_be_i[b]) ?
                             (wr_data_i[8*b +: 8] & IEN_MASK[8*b +: 8]) : ien_q[8*b +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= IEN_RESET;
      ist_q <= '0;
    end else begin
      ien_q <= ien_d;
      ist_q <= ist_d;
    end
  end

  assign latch_o = |set_bits;
  assign drop_o  = (|(clr_bits & ist_q)) && (ist_d == '0);
  assign ien_o   = ien_q;
  assign ist_o   = ist_q;
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int NUM_LOC = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LOC-1:0] latch_i,
  input  logic [NUM_LOC-1:0] drop_i,
  output logic               irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         irq_q <= 1'b0;
    else if (|latch_i)   irq_q <= 1'b1;  // a new latch beats any clear
    else if (|drop_i)    irq_q <= 1'b0;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/loc_irq_ctrl.sv
module loc_irq_ctrl #(
  parameter int NUM_LOC = 5,
  parameter int IRQ_NUM = 11,
  parameter int LOC_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_valid_i,
  input  logic [LOC_W-1:0] evt_loc_i,
  input  logic [3:0]       evt_i,
  input  logic [LOC_W-1:0] active_loc_i,
  input  logic             wr_en_i,
  input  logic [LOC_W-1:0] wr_loc_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [3:0]       wr_be_i,
  input  logic [31:0]      wr_data_i,
  input  logic [LOC_W-1:0] rd_loc_i,
  input  logic [1:0]       rd_sel_i,
  output logic [31:0]      rd_data_o,
  output logic             irq_o
);
  import irq_pkg::*;

  localparam int VEC_NUM = (IRQ_NUM > 15) ? 15 : ((IRQ_NUM < 0) ? 0 : IRQ_NUM);
  localparam logic [31:0] VEC_VAL = 32'(VEC_NUM);

  logic [NUM_LOC-1:0]       hit, latch, drop;
  logic [31:0]              evt_bits;
  logic [NUM_LOC-1:0][31:0] ien_q, ist_q;
  logic                     wr_ok;

  assign wr_ok = wr_en_i && (active_loc_i < LOC_W'(NUM_LOC)) && (wr_loc_i == active_loc_i);

  irq_evt_decode #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_dec (
    .evt_valid_i(evt_valid_i), .evt_loc_i(evt_loc_i), .evt_i(evt_i),
    .hit_o(hit), .bits_o(evt_bits)
  );

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_bank
    logic own;
    assign own = wr_ok && (wr_loc_i == LOC_W'(i));
    irq_loc_bank u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .evt_hit_i(hit[i]), .evt_bits_i(evt_bits),
      .wr_ien_i(own && (wr_sel_i == SEL_ENABLE)),
      .wr_ist_i(own && (wr_sel_i == SEL_STATUS)),
      .wr_be_i(wr_be_i), .wr_data_i(wr_data_i),
      .ien_o(ien_q[i]), .ist_o(ist_q[i]),
      .latch_o(latch[i]), .drop_o(drop[i])
    );
  end

  irq_line #(.NUM_LOC(NUM_LOC)) u_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .latch_i(latch), .drop_i(drop), .irq_o(irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_sel_i == SEL_VECTOR) rd_data_o = VEC_VAL;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (rd_loc_i == LOC_W'(i)) begin
        if (rd_sel_i == SEL_ENABLE) rd_data_o = ien_q[i];
        if (rd_sel_i == SEL_STATUS) rd_data_o = ist_q[i];
      end
    end
  end
endmodule

// File: rtl/loc_irq_chk.sv
module loc_irq_chk #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     evt_valid_i,
  input logic [LOC_W-1:0]         evt_loc_i,
  input logic [LOC_W-1:0]         active_loc_i,
  input logic                     wr_en_i,
  input logic [LOC_W-1:0]         wr_loc_i,
  input logic [1:0]               wr_sel_i,
  input logic [1:0]               rd_sel_i,
  input logic [31:0]              rd_data_o,
  input logic                     irq_o,
  input logic [NUM_LOC-1:0][31:0] ien_q,
  input logic [NUM_LOC-1:0][31:0] ist_q
);
  import irq_pkg::*;

  AST_RISE_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(evt_valid_i)); // R2

  AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_en_i && (wr_sel_i == SEL_STATUS))); // R8

  AST_BAD_LOC_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && (evt_loc_i >= LOC_W'(NUM_LOC)) && !wr_en_i) |=> $stable(ist_q)); // R4

  AST_FOREIGN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_loc_i != active_loc_i) && !evt_valid_i) |=> ($stable(ien_q) && $stable(ist_q))); // R5

  AST_VECTOR_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_sel_i == SEL_VECTOR) && $past(rd_sel_i == SEL_VECTOR)) |->
      ((rd_data_o[31:4] == 28'd0) && $stable(rd_data_o))); // R9

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_rsvd
    AST_IEN_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ien_q[i] & ~IEN_MASK) == 32'd0); // R6
  end
endmodule

bind loc_irq_ctrl loc_irq_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_valid_i(evt_valid_i), .evt_loc_i(evt_loc_i),
  .active_loc_i(active_loc_i), .wr_en_i(wr_en_i), .wr_loc_i(wr_loc_i), .wr_sel_i(wr_sel_i),
  .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .irq_o(irq_o), .ien_q(ien_q), .ist_q(ist_q)
);

// File: tb/sim_loc_irq_ctrl.sv
`timescale 1ns/100ps
module sim_loc_irq_ctrl;
  localparam int NL = 5;
  localparam int IRQN = 11;

  logic clk = 0, rst_n = 0;
  logic evt_valid = 0, wr_en = 0;
  logic [7:0] evt_loc = 0, active_loc = 8'hFF, wr_loc = 0, rd_loc = 0;
  logic [3:0] evt = 0, wr_be = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_ien [NL];
  logic [31:0] m_ist [NL];
  logic        m_irq;

  always #2 clk = ~clk;

  loc_irq_ctrl #(.NUM_LOC(NL), .IRQ_NUM(IRQN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(evt_valid), .evt_loc_i(evt_loc), .evt_i(evt),
    .active_loc_i(active_loc), .wr_en_i(wr_en), .wr_loc_i(wr_loc), .wr_sel_i(wr_sel),
    .wr_be_i(wr_be), .wr_data_i(wr_data), .rd_loc_i(rd_loc), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  function automatic logic [31:0] src_bits(logic [3:0] e);
    return {24'b0, e[3], 4'b0, e[2:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq});
    for (int i = 0; i < NL; i++) begin
      rd_loc = 8'(i); rd_sel = 2'd0; #0.4;
      chk({tag, " enable"}, rd_data, m_ien[i]);
      rd_sel = 2'd1; #0.4;
      chk({tag, " status"}, rd_data, m_ist[i]);
    end
  endtask

  // model update from the requirements, using pre-edge state
  task automatic model_edge();
    logic any_set, any_drop, wok;
    logic [31:0] s, c, n;
    any_set = 0; any_drop = 0;
    wok = wr_en && active_loc < NL && wr_loc == active_loc;
    for (int i = 0; i < NL; i++) begin
      s = (evt_valid && evt_loc == 8'(i) && m_ien[i][31]) ? (src_bits(evt) & m_ien[i] & 32'h87) : 0;
      c = (wok && wr_loc == 8'(i) && wr_sel == 2'd1 && wr_be[0]) ? ({24'b0, wr_data[7:0]} & 32'h87) : 0;
      n = (m_ist[i] & ~c) | s;
      if (s != 0) any_set = 1;
      if ((c & m_ist[i]) != 0 && n == 0) any_drop = 1;
      m_ist[i] = n;
      if (wok && wr_loc == 8'(i) && wr_sel == 2'd0)
        for (int b = 0; b < 4; b++)
          if (wr_be[b]) m_ien[i][8*b +: 8] = wr_data[8*b +: 8] & (32'h8000_009F >> (8*b));
    end
    if (any_set) m_irq = 1; else if (any_drop) m_irq = 0;
  endtask

  task automatic step(logic ev, logic [7:0] el, logic [3:0] eb,
                      logic we, logic [7:0] wl, logic [1:0] ws, logic [3:0] be, logic [31:0] wd);
    @(negedge clk);
    evt_valid = ev; evt_loc = el; evt = eb;
    wr_en = we; wr_loc = wl; wr_sel = ws; wr_be = be; wr_data = wd;
    @(posedge clk);
    model_edge();
    #1;
    evt_valid = 0; wr_en = 0;
  endtask

  task automatic ev_only(logic [7:0] l, logic [3:0] e);
    step(1, l, e, 0, 0, 0, 0, 0);
  endtask

  task automatic wr_only(logic [7:0] l, logic [1:0] s, logic [3:0] be, logic [31:0] d);
    step(0, 0, 0, 1, l, s, be, d);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h1D2E3F);
    for (int i = 0; i < NL; i++) begin m_ien[i] = 32'h8; m_ist[i] = 0; end
    m_irq = 0;
    #9 rst_n = 1;
    #3;
    // R1 reset values
    check_all("R1");
    for (int i = 0; i < NL; i++) begin
      rd_loc = 8'(i); rd_sel = 2'd0; #0.4; chk("R1 enable literal", rd_data, 32'h8);
    end
    // R9 vector readback, vector writes have no effect
    rd_sel = 2'd2; #0.4; chk("R9 vector", rd_data, 32'd11);
    active_loc = 8'd2;
    wr_only(8'd2, 2'd2, 4'hF, 32'hFFFF_FFFF);
    rd_sel = 2'd2; #0.4; chk("R9 vector after write", rd_data, 32'd11);
    check_all("R9");
    // R6 writable mask
    wr_only(8'd2, 2'd0, 4'hF, 32'hFFFF_FFFF);
    rd_loc = 8'd2; rd_sel = 2'd0; #0.4; chk("R6 mask", rd_data, 32'h8000_009F);
    // R2 latch and raise
    ev_only(8'd2, 4'b0001);
    rd_sel = 2'd1; #0.4; chk("R2 status", rd_data, 32'h1);
    chk("R2 irq", {31'b0, irq}, 32'd1);
    ev_only(8'd2, 4'b1000);
    rd_sel = 2'd1; #0.4; chk("R2 cmd ready bit7", rd_data, 32'h81);
    // R3 global off on locality 3
    ev_only(8'd3, 4'b1111);
    check_all("R3 no global");
    // R3 source off: loc2 enable only global + bit1
    wr_only(8'd2, 2'd0, 4'hF, 32'h8000_0002);
    ev_only(8'd2, 4'b0100);
    check_all("R3 source off");
    // R4 invalid localities
    ev_only(8'd5, 4'b1111); check_all("R4 loc5");
    ev_only(8'hFF, 4'b1111); check_all("R4 loc FF");
    // R5 foreign write
    wr_only(8'd1, 2'd0, 4'hF, 32'hFFFF_FFFF); check_all("R5 enable foreign");
    wr_only(8'd1, 2'd1, 4'hF, 32'hFF); check_all("R5 status foreign");
    // R8 partial clear keeps line
    wr_only(8'd2, 2'd1, 4'h1, 32'h01);
    chk("R8 partial keeps irq", {31'b0, irq}, 32'd1);
    check_all("R8 partial");
    // R8 status clear ignored with byte 0 disabled
    wr_only(8'd2, 2'd1, 4'hE, 32'hFF);
    check_all("R8 lane0 off");
    // arm locality 0, latch there, then clear loc2 to empty: line falls anyway
    active_loc = 8'd0;
    wr_only(8'd0, 2'd0, 4'hF, 32'h8000_009F);
    ev_only(8'd0, 4'b0010);
    active_loc = 8'd2;
    wr_only(8'd2, 2'd1, 4'hF, 32'h80);
    chk("R8 drop with other loc set", {31'b0, irq}, 32'd0);
    check_all("R8 drop");
    // R7 byte lanes
    wr_only(8'd2, 2'd0, 4'b0001, 32'hFFFF_FF9F);
    rd_loc = 8'd2; rd_sel = 2'd0; #0.4; chk("R7 lane0", rd_data, 32'h8000_009F);
    wr_only(8'd2, 2'd0, 4'b1000, 32'h0000_00FF);
    rd_sel = 2'd0; #0.4; chk("R7 lane3", rd_data, 32'h0000_009F);
    wr_only(8'd2, 2'd0, 4'b1000, 32'hFF00_0000);
    // R10 event with clear in same cycle
    ev_only(8'd2, 4'b0001);
    step(1, 8'd2, 4'b0010, 1, 8'd2, 2'd1, 4'hF, 32'h01);
    rd_loc = 8'd2; rd_sel = 2'd1; #0.4; chk("R10 status", rd_data, 32'h2);
    chk("R10 irq", {31'b0, irq}, 32'd1);
    step(1, 8'd2, 4'b0001, 1, 8'd2, 2'd1, 4'hF, 32'h03);
    chk("R10 irq same-bit", {31'b0, irq}, 32'd1);
    check_all("R10");
    // R11 read has no side effect
    rd_loc = 8'd2; rd_sel = 2'd1; #0.4;
    @(negedge clk); @(negedge clk);
    chk("R11 reread", rd_data, m_ist[2]);
    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] el, wl;
      logic [31:0] wd;
      if (($urandom % 16) == 0) active_loc = (($urandom % 6) == 5) ? 8'hFF : 8'($urandom % 5);
      el = (($urandom % 9) == 8) ? 8'hFF : 8'($urandom % 8);
      wl = (($urandom % 4) == 0) ? 8'($urandom % 8) : active_loc;
      wd = $urandom;
      if (($urandom % 2) == 0) wd[31] = 1'b1;
      step($urandom % 2 == 0, el, 4'($urandom), $urandom % 3 == 0, wl,
           2'($urandom), 4'($urandom), wd);
      if ((k % 10) == 0) check_all("R2/R3/R4/R5/R7/R8 random");
      else chk("R2/R8 random irq", {31'b0, irq}, {31'b0, m_irq});
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule